// File: doc/BRIEF.md
# Conditional Skip Sequencer

This block sits in the fetch stage of a single-issue 8-bit microcontroller and decides which instructions are annulled after a skip-on-condition instruction. The skip family covers four operations: increment then skip on zero, decrement then skip on zero, skip on bit set, and skip on bit clear. The condition itself is evaluated elsewhere. This block receives a decoded skip strobe together with the condition result, and a per-instruction flag that marks PAGE or BANK prefix instructions.

When a skip is taken, the block annuls the instruction that follows. If that instruction is a PAGE or BANK prefix, the block keeps annulling through the whole run of consecutive prefixes, and also annuls the first non-prefix instruction after the run. Each annulled instruction still takes its slot, so it costs one cycle. The block asserts `out_squash` for every annulled instruction and clears the side-effect enables that travel with it. It also reports how many cycles the most recent taken skip has consumed, counting the skip itself.

Instructions flow through the block on a valid/ready stream and are not buffered. `in_ready` follows `out_ready` and `out_valid` follows `in_valid` in the same cycle. An instruction advances only in a cycle where `in_valid` and `out_ready` are both high. In any other cycle the sequencer state and the cycle counter hold, and back-pressure passes straight through to the upstream fetch.

Top module: `skip_seq_top`

## Requirements
- R1: After reset `skip_busy` is 0, `skip_cycles` is 0 and no instruction is squashed.
- R2: An accepted, unsquashed skip instruction whose condition input is 0 squashes nothing. The next instruction leaves with `out_squash` = 0.
- R3: An accepted, unsquashed skip with condition 1, followed by a non-prefix instruction, squashes exactly that one instruction. The instruction after it is not squashed, and `skip_cycles` becomes 2.
- R4: A taken skip followed by one prefix instruction (`in_is_prefix` = 1) and then a non-prefix instruction squashes both of them. `skip_cycles` ends at 3.
- R5: A taken skip followed by k consecutive prefix instructions squashes all k of them plus the next non-prefix instruction. `skip_cycles` ends at k+2.
- R6: A skip instruction that is itself squashed starts no new skip, whatever its condition input. Once the annulment ends, the next instruction is not squashed.
- R7: `out_fx` equals `in_fx` for an unsquashed instruction and is all zeros for a squashed one. The enables carry register writes, PAGE/BANK updates and stack operations.
- R8: `in_ready` equals `out_ready` and `out_valid` equals `in_valid`. In a cycle without both `in_valid` and `out_ready`, the squash state and `skip_cycles` hold their values.
- R9: `skip_cycles` saturates at 2^CNT_W-1 (15 by default) and does not wrap.
- R10: A prefix instruction that arrives while no skip is pending is not squashed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | An instruction is offered this cycle |
| in_ready | output | 1 | The block accepts the offered instruction |
| in_is_skip | input | 1 | The offered instruction is a skip-on-condition operation |
| in_cond | input | 1 | Evaluated condition of the skip (1 = skip) |
| in_is_prefix | input | 1 | The offered instruction is a PAGE or BANK prefix |
| in_fx | input | FX_W | Side-effect enables of the offered instruction |
| out_valid | output | 1 | The instruction is presented downstream |
| out_ready | input | 1 | Downstream can take the instruction |
| out_squash | output | 1 | The presented instruction is annulled (no-op) |
| out_fx | output | FX_W | Side-effect enables after squashing |
| skip_busy | output | 1 | An annulment is pending for the next accepted instruction |
| skip_cycles | output | CNT_W | Cycles consumed by the latest taken skip, including the skip itself |

## Verification
The critical overlap is a skip instruction that arrives while it is being annulled. In that cycle the squash logic and the skip-start logic both see the same instruction. The bench provokes this overlap in several ways: a squashed skip with its condition true, directly after a taken skip; a squashed skip that closes a run of prefixes; and a squashed skip held under back-pressure. A behavioural model compares `out_squash`, `out_fx`, `skip_busy` and `skip_cycles` on every cycle. The model also checks that the instruction after the squashed skip executes normally.

// File: rtl/skip_seq_pkg.sv
package skip_seq_pkg;
  typedef enum logic {
    SEQ_RUN   = 1'b0,
    SEQ_ANNUL = 1'b1
  } seq_state_t;
endpackage

// File: rtl/skip_seq_fsm.sv
module skip_seq_fsm
  import skip_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic is_skip,
  input  logic cond,
  input  logic is_prefix,
  output logic annul_now,
  output logic start_skip,
  output logic bump
);
  seq_state_t state_q, state_d;

  assign annul_now  = (state_q == SEQ_ANNUL);
  assign start_skip = accept && !annul_now && is_skip && cond;
  assign bump       = accept && annul_now;

  always_comb begin
    state_d = state_q;
    if (accept) begin
      if (annul_now) begin
        if (!is_prefix) state_d = SEQ_RUN;
      end else if (is_skip && cond) begin
        state_d = SEQ_ANNUL;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEQ_RUN;
    else        state_q <= state_d;
  end

  // R3 / R6: a non-prefix instruction ends the annulment, even a skip
  a_r3_clear_on_plain: assert property (@(posedge clk) disable iff (!rst_n)
    (annul_now && accept && !is_prefix) |=> !annul_now);
  // R5: a prefix keeps the annulment alive
  a_r5_prefix_extends: assert property (@(posedge clk) disable iff (!rst_n)
    (annul_now && accept && is_prefix) |=> annul_now);
  // R2: an unsquashed instruction without a true skip condition leaves the state idle
  a_r2_false_no_annul: assert property (@(posedge clk) disable iff (!rst_n)
    (!annul_now && accept && !(is_skip && cond)) |=> !annul_now);
  // R8: without a transfer the state holds
  a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(annul_now));
endmodule

// File: rtl/skip_seq_counter.sv
module skip_seq_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             bump,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;
  assign count = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cnt_q <= '0;
    else if (load)                     cnt_q <= CNT_ONE;
    else if (bump && cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_ONE;
  end

  // R9: a full counter stays full while annulled instructions keep arriving
  a_r9_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (bump && !load && cnt_q == CNT_MAX) |=> cnt_q == CNT_MAX);
  // R8: no load and no bump, no change
  a_r8_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!bump && !load) |=> $stable(cnt_q));
endmodule

// File: rtl/skip_seq_fx_gate.sv
module skip_seq_fx_gate #(
  parameter int FX_W = 3
) (
  input  logic            squash,
  input  logic [FX_W-1:0] fx_in,
  output logic [FX_W-1:0] fx_out
);
  for (genvar g = 0; g < FX_W; g++) begin : g_lane
    assign fx_out[g] = fx_in[g] & ~squash;
  end

  // R7: an annulled instruction carries no side effect
  always_comb begin
    a_r7_no_effect: assert (!(squash && (fx_out != '0)));
  end
endmodule

// File: rtl/skip_seq_top.sv
module skip_seq_top #(
  parameter int FX_W  = 3,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_is_skip,
  input  logic             in_cond,
  input  logic             in_is_prefix,
  input  logic [FX_W-1:0]  in_fx,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_squash,
  output logic [FX_W-1:0]  out_fx,
  output logic             skip_busy,
  output logic [CNT_W-1:0] skip_cycles
);
  logic accept, annul_now, start_skip, bump;

  assign in_ready   = out_ready;
  assign out_valid  = in_valid;
  assign accept     = in_valid && out_ready;
  assign out_squash = annul_now && in_valid;
  assign skip_busy  = annul_now;

  skip_seq_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .is_skip    (in_is_skip),
    .cond       (in_cond),
    .is_prefix  (in_is_prefix),
    .annul_now  (annul_now),
    .start_skip (start_skip),
    .bump       (bump)
  );

  skip_seq_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (start_skip),
    .bump  (bump),
    .count (skip_cycles)
  );

  skip_seq_fx_gate #(.FX_W(FX_W)) u_fx (
    .squash (out_squash),
    .fx_in  (in_fx),
    .fx_out (out_fx)
  );

  // R6: a squashed skip never restarts the count
  a_r6_squashed_skip_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (out_squash && accept && in_is_skip && in_cond && !in_is_prefix) |=> !skip_busy);
  // R10: an idle prefix passes through unannulled
  always_comb begin
    a_r10_idle_prefix: assert (!(in_valid && !skip_busy && out_squash));
  end
endmodule

// File: tb/skip_seq_top_tb_top.sv
module skip_seq_top_tb_top;
  localparam int FX_W  = 3;
  localparam int CNT_W = 4;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_is_skip = 1'b0, in_cond = 1'b0, in_is_prefix = 1'b0;
  logic out_ready = 1'b1;
  logic [FX_W-1:0] in_fx = '0;
  logic in_ready, out_valid, out_squash, skip_busy;
  logic [FX_W-1:0] out_fx;
  logic [CNT_W-1:0] skip_cycles;

  int total = 0;
  int bad = 0;
  bit ref_pend = 0;
  int ref_cnt = 0;

  always #4 clk = ~clk;

  skip_seq_top #(.FX_W(FX_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_is_skip(in_is_skip), .in_cond(in_cond), .in_is_prefix(in_is_prefix),
    .in_fx(in_fx), .out_valid(out_valid), .out_ready(out_ready),
    .out_squash(out_squash), .out_fx(out_fx), .skip_busy(skip_busy),
    .skip_cycles(skip_cycles)
  );

  task automatic chk(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // one cycle: drive at negedge, compare, then advance model for the coming edge
  task automatic step(string tag, bit v, bit rdy, bit sk, bit cd, bit pf, int fx);
    bit acc;
    @(negedge clk);
    in_valid = v; out_ready = rdy; in_is_skip = sk; in_cond = cd;
    in_is_prefix = pf; in_fx = fx[FX_W-1:0];
    #1;
    chk(tag, "out_squash", int'(out_squash), int'(ref_pend && v));
    chk(tag, "out_fx", int'(out_fx), (ref_pend && v) ? 0 : fx);
    chk(tag, "skip_busy", int'(skip_busy), int'(ref_pend));
    chk(tag, "skip_cycles", int'(skip_cycles), ref_cnt);
    chk("R8", "in_ready", int'(in_ready), int'(rdy));
    chk("R8", "out_valid", int'(out_valid), int'(v));
    acc = v && rdy;
    if (acc) begin
      if (ref_pend) begin
        if (ref_cnt < CMAX) ref_cnt++;
        if (!pf) ref_pend = 0;
      end else if (sk && cd) begin
        ref_pend = 1;
        ref_cnt = 1;
      end
    end
  endtask

  task automatic settle_cnt(string tag, int exp);
    @(negedge clk); in_valid = 0; #1;
    chk(tag, "final skip_cycles", int'(skip_cycles), exp);
  endtask

  initial begin
    #1600000;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    #1;
    chk("R1", "skip_busy", int'(skip_busy), 0);
    chk("R1", "skip_cycles", int'(skip_cycles), 0);
    chk("R1", "out_squash", int'(out_squash), 0);
    rst_n = 1'b1;

    // R2 false condition
    step("R2", 1, 1, 1, 0, 0, 7);
    step("R2", 1, 1, 0, 0, 0, 5);
    // R10 idle prefix
    step("R10", 1, 1, 0, 0, 1, 3);
    step("R10", 1, 1, 0, 0, 0, 1);
    // R3 plain taken skip
    step("R3", 1, 1, 1, 1, 0, 7);
    step("R3", 1, 1, 0, 0, 0, 7);
    step("R3", 1, 1, 0, 0, 0, 6);
    settle_cnt("R3", 2);
    // R4 one prefix
    step("R4", 1, 1, 1, 1, 0, 0);
    step("R4", 1, 1, 0, 0, 1, 2);
    step("R4", 1, 1, 0, 0, 0, 4);
    step("R4", 1, 1, 0, 0, 0, 4);
    settle_cnt("R4", 3);
    // R5 three prefixes
    step("R5", 1, 1, 1, 1, 0, 0);
    for (int i = 0; i < 3; i++) step("R5", 1, 1, 0, 0, 1, 7);
    step("R5", 1, 1, 0, 0, 0, 7);
    step("R5", 1, 1, 0, 0, 0, 7);
    settle_cnt("R5", 5);
    // R6 squashed taken skip right after a taken skip
    step("R6", 1, 1, 1, 1, 0, 0);
    step("R6", 1, 1, 1, 1, 0, 7);
    step("R6", 1, 1, 0, 0, 0, 7);
    settle_cnt("R6", 2);
    // R6 squashed skip closing a prefix run, with stalls
    step("R6", 1, 1, 1, 1, 0, 0);
    step("R6", 1, 1, 0, 0, 1, 7);
    step("R8", 1, 0, 1, 1, 0, 7);
    step("R8", 0, 1, 1, 1, 0, 7);
    step("R6", 1, 1, 1, 1, 0, 7);
    step("R6", 1, 1, 0, 0, 0, 5);
    settle_cnt("R6", 3);
    // R7 side effects on squashed vs live
    step("R7", 1, 1, 1, 1, 0, 7);
    step("R7", 1, 1, 0, 0, 0, 7);
    step("R7", 1, 1, 0, 0, 0, 7);
    // R9 saturation with a long prefix run
    step("R9", 1, 1, 1, 1, 0, 0);
    for (int i = 0; i < 16; i++) step("R9", 1, 1, 0, 0, 1, 1);
    step("R9", 1, 1, 0, 0, 0, 1);
    step("R9", 1, 1, 0, 0, 0, 1);
    settle_cnt("R9", CMAX);
    // mixed pattern
    for (int i = 0; i < 40; i++)
      step("R5", (i % 7) != 3, (i % 5) != 2, (i % 3) == 0, (i % 4) != 1, (i % 6) == 2, i % 8);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule